// File: doc/BRIEF.md
# Three-Wire Configuration Register Bank

This block is the write-only programming port of a frequency-agile transmitter. A host drives three slow pins (a serial clock, a serial data line and a load strobe) that the block samples with its own system clock. Bits are shifted into a 24-bit register. A rising strobe then commits that register to one of five storage latches, picked by an address prefix of variable length at the top of the word. Two latches hold 22-bit channel (synthesizer frequency) words. Two hold control words for the two operating banks. The fifth is a test latch whose nonzero contents raise a test-mode flag.

The block's outputs present the enables and amplifier level of the bank that the `mode_sel` pin picks, together with the matching channel word. They also carry the global settings held in the bank-1 control word: feedback divider select, acquisition-aid multiplier and modulation mode. The deviation byte comes from the bank-0 control word. When `stdby_n` is low, every block enable is forced off. The stored words stay intact and new writes are still taken, so a standby exit resumes at once with the programmed settings.

The bank pins act combinationally on the outputs. Only the serial pins pass through synchronizers. The serial pins are plain control inputs with no handshake: the host must keep the serial clock and data low while the strobe is high.

Top module: `cfg_serial_bank`

## Requirements
- R1: Each rising edge of the serial clock shifts the data pin into the low end of a 24-bit register, so the first bit sent ends up in bit 23.
- R2: When more than 24 bits are clocked before a strobe, only the most recent 24 are kept.
- R3: A strobe with word bits [23:22] = 00 loads bits [21:0] into channel word 0; bits [23:22] = 01 loads channel word 1. `freq_word` shows channel word 0 when `mode_sel` = 0 and channel word 1 when `mode_sel` = 1.
- R4: A strobe with bits [23:21] = 101 loads the bank-1 control word. Its fields are: acquisition code [20:18], divide select [17] (1 selects divide-by-512), modulation mode [16], PLL enable [12], VCO enable [11], amplifier level [10:9]. The divide select and modulation mode drive `div512` and `mod_mode` whatever the bank pins are.
- R5: A strobe with bits [23:21] = 110 loads the bank-0 control word. Its fields are: deviation [20:13], which drives `dev_word`, PLL enable [12], VCO enable [11], amplifier level [10:9].
- R6: `mode_sel` = 0 routes the bank-0 enables and level to the outputs, and `mode_sel` = 1 routes the bank-1 ones.
- R7: `pa_level` carries the routed 2-bit level (00 off, 01 10 dB attenuation, 10 20 dB attenuation, 11 0 dB attenuation). `mod_en` is high exactly when that level is nonzero.
- R8: `acq_factor` decodes the acquisition code: 000→1, 001→20, 010→40, 011→60, 111→140. The reserved codes 100, 101 and 110 decode to 1.
- R9: A strobe with bits [23:21] = 111 loads the test latch from bits [20:0]. `test_mode` is high while that payload is nonzero and drops only after an all-zero payload is written or the block is reset.
- R10: After reset every latch is zero. Every output is then zero, except `acq_factor`, which is 1.
- R11: While `stdby_n` is low, `pa_level`, `mod_en`, `vco_en` and `pll_en` are 0. The latch contents are kept, writes made during standby take effect, and the stored settings reappear when `stdby_n` returns high.
- R12: A strobe with bits [23:21] = 100 is reserved and changes no latch and no output.
- R13: Shifting bits without a strobe leaves every latch and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_data | input | 1 | Serial data, MSB first |
| ser_strobe | input | 1 | Load strobe, acts on its rising edge |
| mode_sel | input | 1 | Bank select (0 = bank 0, 1 = bank 1) |
| stdby_n | input | 1 | Active-low standby |
| freq_word | output | 22 | Channel word of the selected bank |
| dev_word | output | 8 | Deviation byte from the bank-0 control word |
| pa_level | output | 2 | Amplifier level of the selected bank, gated by standby |
| mod_en | output | 1 | Data modulation enabled |
| vco_en | output | 1 | Oscillator enable of the selected bank, gated |
| pll_en | output | 1 | Synthesizer loop enable of the selected bank, gated |
| div512 | output | 1 | Feedback divider select (1 = 512) |
| acq_factor | output | 8 | Decoded acquisition-aid multiplier |
| mod_mode | output | 1 | Modulation mode bit |
| test_mode | output | 1 | Test latch holds a nonzero payload |

## Verification
The bench builds the block with its default widths and a two-stage synchronizer, so a strobe commits within three system clocks of its pin edge. Each serial bit phase is held for four system clocks. Under these values every address code, including the reserved one, every acquisition code and both bank and standby pin states can be reached by random words mixed with directed ones. The directed words cover overlong shifts, shifting without a strobe and the test latch's set and clear.

// File: rtl/cfg_bank_pkg.sv
`timescale 1ns/1ps
package cfg_bank_pkg;
  parameter int WORD_W = 24;
  parameter int CH_W   = 22;
  parameter int CTL_W  = 21;
  parameter int ACQ_W  = 8;
  parameter int DEV_W  = 8;

  // control word field positions (decoded by the synthesizer)
  localparam int ACQ_HI = 20;
  localparam int DIV_B  = 17;
  localparam int MOD_B  = 16;
  localparam int DEV_HI = 20;
  localparam int PLL_B  = 12;
  localparam int VCO_B  = 11;
  localparam int PA_HI  = 10;

  typedef struct packed {
    logic       pll_en;
    logic       vco_en;
    logic [1:0] pa;
  } bank_ctl_t;

  typedef struct packed {
    logic [2:0] acq;
    logic       div512;
    logic       mod_mode;
    bank_ctl_t  bank;
  } ctl_b1_t;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    bank_ctl_t        bank;
  } ctl_b0_t;

  typedef enum logic [2:0] {
    TGT_RSV  = 3'b100,
    TGT_CTL1 = 3'b101,
    TGT_CTL0 = 3'b110,
    TGT_TEST = 3'b111
  } ctl_tgt_e;

  function automatic logic [ACQ_W-1:0] acq_decode(input logic [2:0] code);
    case (code)
      3'b001:  acq_decode = ACQ_W'(20);
      3'b010:  acq_decode = ACQ_W'(40);
      3'b011:  acq_decode = ACQ_W'(60);
      3'b111:  acq_decode = ACQ_W'(140);
      default: acq_decode = ACQ_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/cfg_shift_in.sv
`timescale 1ns/1ps
module cfg_shift_in #(
  parameter int WORD_W = 24,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  output logic [WORD_W-1:0] shreg,
  output logic              clk_rise,
  output logic              load_pulse
);
  localparam int LAST = SYNC_N - 1;

  logic [SYNC_N-1:0] clk_pipe, dat_pipe, stb_pipe;
  logic              clk_prev, stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      stb_pipe <= '0;
      clk_prev <= 1'b0;
      stb_prev <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[SYNC_N-2:0], ser_clk};
      dat_pipe <= {dat_pipe[SYNC_N-2:0], ser_data};
      stb_pipe <= {stb_pipe[SYNC_N-2:0], ser_strobe};
      clk_prev <= clk_pipe[LAST];
      stb_prev <= stb_pipe[LAST];
    end
  end

  assign clk_rise   = clk_pipe[LAST] & ~clk_prev;
  assign load_pulse = stb_pipe[LAST] & ~stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (clk_rise) shreg <= {shreg[WORD_W-2:0], dat_pipe[LAST]};
  end
endmodule

// File: rtl/cfg_latch_bank.sv
`timescale 1ns/1ps
module cfg_latch_bank
  import cfg_bank_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CH_W,
  parameter int TW = CTL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_pulse,
  input  logic [W-1:0]  shreg,
  output logic [CW-1:0] ch0,
  output logic [CW-1:0] ch1,
  output ctl_b1_t       ctl1,
  output ctl_b0_t       ctl0,
  output logic [TW-1:0] tst
);
  ctl_tgt_e tgt;
  bank_ctl_t bank_in;
  assign tgt     = ctl_tgt_e'(shreg[W-1:W-3]);
  assign bank_in = '{pll_en: shreg[PLL_B], vco_en: shreg[VCO_B],
                     pa: shreg[PA_HI:PA_HI-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch0  <= '0;
      ch1  <= '0;
      ctl1 <= '0;
      ctl0 <= '0;
      tst  <= '0;
    end else if (load_pulse) begin
      if (!shreg[W-1]) begin
        if (shreg[W-2]) ch1 <= shreg[CW-1:0];
        else            ch0 <= shreg[CW-1:0];
      end else begin
        case (tgt)
          TGT_CTL1: ctl1 <= '{acq: shreg[ACQ_HI:ACQ_HI-2], div512: shreg[DIV_B],
                              mod_mode: shreg[MOD_B], bank: bank_in};
          TGT_CTL0: ctl0 <= '{dev: shreg[DEV_HI:DEV_HI-DEV_W+1], bank: bank_in};
          TGT_TEST: tst  <= shreg[TW-1:0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_bank_select.sv
`timescale 1ns/1ps
module cfg_bank_select
  import cfg_bank_pkg::*;
#(
  parameter int CW = CH_W,
  parameter int TW = CTL_W
) (
  input  logic             mode_sel,
  input  logic             stdby_n,
  input  logic [CW-1:0]    ch0,
  input  logic [CW-1:0]    ch1,
  input  ctl_b1_t          ctl1,
  input  ctl_b0_t          ctl0,
  input  logic [TW-1:0]    tst,
  output logic [CW-1:0]    freq_word,
  output logic [DEV_W-1:0] dev_word,
  output logic [1:0]       pa_level,
  output logic             mod_en,
  output logic             vco_en,
  output logic             pll_en,
  output logic             div512,
  output logic [ACQ_W-1:0] acq_factor,
  output logic             mod_mode,
  output logic             test_mode
);
  bank_ctl_t cur;

  always_comb begin
    cur       = mode_sel ? ctl1.bank : ctl0.bank;
    freq_word = mode_sel ? ch1 : ch0;
    pa_level  = stdby_n ? cur.pa : 2'b00;
    vco_en    = stdby_n & cur.vco_en;
    pll_en    = stdby_n & cur.pll_en;
    mod_en    = |pa_level;
  end

  assign dev_word   = ctl0.dev;
  assign div512     = ctl1.div512;
  assign mod_mode   = ctl1.mod_mode;
  assign acq_factor = acq_decode(ctl1.acq);
  assign test_mode  = |tst;
endmodule

// File: rtl/cfg_serial_bank.sv
`timescale 1ns/1ps
module cfg_serial_bank
  import cfg_bank_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_strobe,
  input  logic             mode_sel,
  input  logic             stdby_n,
  output logic [CH_W-1:0]  freq_word,
  output logic [DEV_W-1:0] dev_word,
  output logic [1:0]       pa_level,
  output logic             mod_en,
  output logic             vco_en,
  output logic             pll_en,
  output logic             div512,
  output logic [ACQ_W-1:0] acq_factor,
  output logic             mod_mode,
  output logic             test_mode
);
  logic [WORD_W-1:0] shreg_q;
  logic              clk_rise, load_pulse;
  logic [CH_W-1:0]   ch0_q, ch1_q;
  ctl_b1_t           ctl1_q;
  ctl_b0_t           ctl0_q;
  logic [CTL_W-1:0]  tst_q;

  cfg_shift_in #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .shreg(shreg_q), .clk_rise(clk_rise),
    .load_pulse(load_pulse)
  );

  cfg_latch_bank u_latch (
    .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse), .shreg(shreg_q),
    .ch0(ch0_q), .ch1(ch1_q), .ctl1(ctl1_q), .ctl0(ctl0_q), .tst(tst_q)
  );

  cfg_bank_select u_sel (
    .mode_sel(mode_sel), .stdby_n(stdby_n), .ch0(ch0_q), .ch1(ch1_q),
    .ctl1(ctl1_q), .ctl0(ctl0_q), .tst(tst_q), .freq_word(freq_word),
    .dev_word(dev_word), .pa_level(pa_level), .mod_en(mod_en),
    .vco_en(vco_en), .pll_en(pll_en), .div512(div512),
    .acq_factor(acq_factor), .mod_mode(mod_mode), .test_mode(test_mode)
  );
endmodule

// File: rtl/cfg_serial_bank_chk.sv
`timescale 1ns/1ps
module cfg_serial_bank_chk
  import cfg_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stdby_n,
  input logic [1:0]        pa_level,
  input logic              mod_en,
  input logic              vco_en,
  input logic              pll_en,
  input logic [ACQ_W-1:0]  acq_factor,
  input logic              test_mode,
  input logic              clk_rise,
  input logic              load_pulse,
  input logic [WORD_W-1:0] shreg,
  input logic [CH_W-1:0]   ch0,
  input logic [CH_W-1:0]   ch1,
  input ctl_b1_t           ctl1,
  input ctl_b0_t           ctl0,
  input logic [CTL_W-1:0]  tst
);
  logic [2*CH_W+2*CTL_W-1:0] all_latch;
  assign all_latch = {ch0, ch1, ctl1, ctl0, tst};

  // R11
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stdby_n |-> (pa_level == 2'b00 && !vco_en && !pll_en && !mod_en));

  // R7
  mod_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |-> pa_level != 2'b00);

  // R8
  acq_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_factor inside {8'd1, 8'd20, 8'd40, 8'd60, 8'd140});

  // R9
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_mode) |-> $past(load_pulse));

  // R1
  shift_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shreg) |-> $past(clk_rise));

  // R13
  latch_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(all_latch) |-> $past(load_pulse));

  // R12
  reserved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && shreg[WORD_W-1:WORD_W-3] == 3'b100) |=> $stable(all_latch));
endmodule

bind cfg_serial_bank cfg_serial_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stdby_n(stdby_n), .pa_level(pa_level),
  .mod_en(mod_en), .vco_en(vco_en), .pll_en(pll_en), .acq_factor(acq_factor),
  .test_mode(test_mode), .clk_rise(clk_rise), .load_pulse(load_pulse),
  .shreg(shreg_q), .ch0(ch0_q), .ch1(ch1_q), .ctl1(ctl1_q), .ctl0(ctl0_q),
  .tst(tst_q)
);

// File: tb/cfg_serial_bank_bench.sv
`timescale 1ns/1ps
module cfg_serial_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
  logic mode_sel = 1'b0, stdby_n = 1'b1;
  logic [21:0] freq_word;
  logic [7:0]  dev_word, acq_factor;
  logic [1:0]  pa_level;
  logic mod_en, vco_en, pll_en, div512, mod_mode, test_mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the five latches
  logic [21:0] m_ch0 = '0, m_ch1 = '0;
  logic [20:0] m_c1 = '0, m_c0 = '0, m_t = '0;

  always #2.5 clk = ~clk;

  cfg_serial_bank u_cfg_serial_bank (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .mode_sel(mode_sel), .stdby_n(stdby_n),
    .freq_word(freq_word), .dev_word(dev_word), .pa_level(pa_level),
    .mod_en(mod_en), .vco_en(vco_en), .pll_en(pll_en), .div512(div512),
    .acq_factor(acq_factor), .mod_mode(mod_mode), .test_mode(test_mode)
  );

  function automatic logic [7:0] exp_acq(input logic [2:0] c);
    if (c == 3'd1) return 8'd20;
    if (c == 3'd2) return 8'd40;
    if (c == 3'd3) return 8'd60;
    if (c == 3'd7) return 8'd140;
    return 8'd1;
  endfunction

  function automatic void model_write(input logic [23:0] w);
    if (w[23:22] == 2'b00)      m_ch0 = w[21:0];
    else if (w[23:22] == 2'b01) m_ch1 = w[21:0];
    else if (w[23:21] == 3'b101) m_c1 = w[20:0];
    else if (w[23:21] == 3'b110) m_c0 = w[20:0];
    else if (w[23:21] == 3'b111) m_t  = w[20:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [20:0] cur;
    logic [1:0]  pa;
    cur = mode_sel ? m_c1 : m_c0;
    pa  = stdby_n ? cur[10:9] : 2'b00;
    chk(req, "freq_word", 32'(freq_word), 32'(mode_sel ? m_ch1 : m_ch0));
    chk(req, "dev_word", 32'(dev_word), 32'(m_c0[20:13]));
    chk(req, "pa_level", 32'(pa_level), 32'(pa));
    chk(req, "mod_en", 32'(mod_en), 32'(pa != 2'b00));
    chk(req, "vco_en", 32'(vco_en), 32'(stdby_n & cur[11]));
    chk(req, "pll_en", 32'(pll_en), 32'(stdby_n & cur[12]));
    chk(req, "div512", 32'(div512), 32'(m_c1[17]));
    chk(req, "mod_mode", 32'(mod_mode), 32'(m_c1[16]));
    chk(req, "acq_factor", 32'(acq_factor), 32'(exp_acq(m_c1[20:18])));
    chk(req, "test_mode", 32'(test_mode), 32'(m_t != '0));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b;
    repeat (4) @(negedge clk); ser_clk = 1'b1;
    repeat (4) @(negedge clk); ser_clk = 1'b0; ser_data = 1'b0;
  endtask

  task automatic shift_word(input logic [23:0] w, input int lead);
    for (int i = 0; i < lead; i++) send_bit(1'($urandom));
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); ser_strobe = 1'b1;
    repeat (4) @(negedge clk); ser_strobe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_word(input logic [23:0] w, input int lead);
    shift_word(w, lead);
    strobe();
    model_write(w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state, both banks
    check_all("R10");
    mode_sel = 1'b1; #1; check_all("R10");
    mode_sel = 1'b0;

    // R1 MSB first into channel word 0
    write_word(24'h2A5A5C & 24'h3FFFFF, 0);
    check_all("R1");
    chk("R1", "freq_word pattern", 32'(freq_word), 32'h2A5A5C);

    // R2 overlong shift keeps the last 24 bits
    write_word(24'h4ABCDE, 7);
    mode_sel = 1'b1; #1;
    chk("R2", "freq_word overlong", 32'(freq_word), 32'h0ABCDE);
    check_all("R2");

    // R3 channel words by bank pin
    mode_sel = 1'b0; #1; check_all("R3");

    // R4 bank-1 control: acq 111, div 1, mod 1, pll, vco, level 11
    write_word({3'b101, 3'b111, 1'b1, 1'b1, 3'b000, 1'b1, 1'b1, 2'b11, 9'h000}, 0);
    mode_sel = 1'b1; #1; check_all("R4");
    chk("R4", "acq 140", 32'(acq_factor), 32'd140);

    // R5 bank-0 control: dev 0xA5, pll 1, vco 0, level 01
    write_word({3'b110, 8'hA5, 1'b1, 1'b0, 2'b01, 9'h1FF}, 0);
    mode_sel = 1'b0; #1; check_all("R5");
    chk("R5", "dev_word", 32'(dev_word), 32'hA5);

    // R6 / R7 bank pin swaps enables and level
    chk("R7", "level 01 mod_en", 32'(mod_en), 32'd1);
    mode_sel = 1'b1; #1; check_all("R6");
    chk("R6", "bank1 level", 32'(pa_level), 32'd3);

    // R8 reserved acquisition code decodes to 1
    write_word({3'b101, 3'b101, 18'h0}, 0);
    check_all("R8");
    chk("R8", "acq reserved", 32'(acq_factor), 32'd1);
    chk("R7", "level 00 mod_en", 32'(mod_en), 32'd0);

    // R12 reserved address changes nothing
    write_word({3'b100, 21'h1FFFFF}, 0);
    check_all("R12");

    // R13 shift without strobe changes nothing
    shift_word(24'h3FFFFF, 0);
    check_all("R13");
    strobe(); model_write(24'h3FFFFF);
    mode_sel = 1'b0; #1; check_all("R13");

    // R9 test latch set, kept across other writes, cleared by zero
    write_word({3'b111, 21'h000100}, 0);
    chk("R9", "test set", 32'(test_mode), 32'd1);
    write_word(24'h012345, 0);
    chk("R9", "test held", 32'(test_mode), 32'd1);
    write_word({3'b111, 21'h0}, 0);
    chk("R9", "test cleared", 32'(test_mode), 32'd0);

    // R11 standby gating, write accepted in standby
    stdby_n = 1'b0; #1; check_all("R11");
    write_word({3'b110, 8'h3C, 1'b1, 1'b1, 2'b10, 9'h0}, 0);
    check_all("R11");
    stdby_n = 1'b1; #1; check_all("R11");
    chk("R11", "level after standby", 32'(pa_level), 32'd2);

    // random words across all targets, bank and standby states
    for (int n = 0; n < 40; n++) begin
      logic [23:0] w;
      int k;
      w = 24'($urandom);
      k = int'($urandom % 6);
      case (k)
        0: w[23:22] = 2'b00;
        1: w[23:22] = 2'b01;
        2: w[23:21] = 3'b101;
        3: w[23:21] = 3'b110;
        4: w[23:21] = 3'b111;
        default: w[23:21] = 3'b100;
      endcase
      write_word(w, int'($urandom % 3));
      mode_sel = 1'($urandom);
      stdby_n  = ($urandom % 4) != 0;
      #1;
      case (k)
        0, 1: check_all("R3");
        2: check_all("R4");
        3: check_all("R5");
        4: check_all("R9");
        default: check_all("R12");
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule